// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level translation structure held in memory. A requester hands it a linear address together with the per-process directory base. The walker fetches one directory entry, then, for a small page, one table entry, through a single-request memory read port. It reports either the physical address or a fault that names the level where the walk stopped.

The linear address is cut into a directory index (top field), a table index (middle field) and a byte offset (low field), 10/10/12 bits by default. A directory entry can map a large page (4 MB by default) directly, and the walk then finishes without a second read. Only one memory read is in flight at any time. A new translation is taken only while the walker is idle.

The controller has four states. IDLE waits for a request. READ_DIR issues the directory read and waits for its data. READ_PTE issues the table read and waits for its data. DONE presents the result for one cycle. The transitions are: IDLE→READ_DIR on an accepted request. READ_DIR→DONE on a not-present or large-page directory entry. READ_DIR→READ_PTE on a present small-page directory entry. READ_PTE→DONE on table data. DONE→IDLE unconditionally.

Top module: `pgwalk_top`

## Requirements
- R1: After reset `req_ready` is 1 and `mem_rd_req` and `resp_valid` are 0. `req_ready` is 1 only in IDLE.
- R2: In the cycle after a request is accepted, `mem_rd_req` is 1 with `mem_rd_addr` = directory base + directory index × 4, where the directory index is linear address bits 31:22.
- R3: `mem_rd_req` is a one-cycle pulse, and no new read is issued until `mem_rd_valid` has returned data for the previous one.
- R4: A directory entry with bit 0 (present) clear ends the walk with `resp_fault`=1, `resp_level`=0, `resp_paddr`=0 and `resp_large`=0, after exactly one read. Bit 7 is then irrelevant.
- R5: A present directory entry with bit 7 set ends the walk after one read, with `resp_large`=1, `resp_fault`=0 and `resp_paddr` = {entry[31:22], linear[21:0]}.
- R6: A present directory entry with bit 7 clear causes a second read at {entry[31:12], 12'b0} + table index × 4, where the table index is linear address bits 21:12.
- R7: A table entry with bit 0 clear ends the walk with `resp_fault`=1, `resp_level`=1 and `resp_paddr`=0.
- R8: A table entry with bit 0 set gives `resp_paddr` = {entry[31:12], linear[11:0]} and `resp_fault`=0. Bit 7 of a table entry has no effect.
- R9: `resp_valid` is a one-cycle pulse in the cycle after the final `mem_rd_valid` is captured. `req_ready` returns to 1 in the following cycle.
- R10: `req_valid` while busy is ignored, and `mem_rd_valid` with no read outstanding is ignored.
- R11: The linear address and directory base are sampled at acceptance. Later changes on those inputs do not affect the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Linear address to translate |
| dir_base | input | 32 | Directory base of the current process |
| req_ready | output | 1 | Walker idle, request accepted |
| mem_rd_req | output | 1 | One-cycle read request pulse |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry read from memory |
| resp_valid | output | 1 | Result pulse |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| resp_fault | output | 1 | Walk ended on a not-present entry |
| resp_level | output | 1 | Fault level: 0 directory, 1 table |
| resp_large | output | 1 | Translation came from a large-page directory entry |

## Verification
The bench uses the default split: 10 directory-index bits, 10 table-index bits and 12 offset bits, with the present flag at bit 0 and the large flag at bit 7. At this width the index values 0 and 1023 are both reachable, as is the largest large-page offset, so the extremes of the entry-address adder and of both offset merges are covered. The memory model's read latency can be set from 1 to 3 cycles. This makes it possible to hold a walk in a wait state long enough to present a request while busy, and to inject a stray data strobe while idle.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_READ_DIR = 2'd1,
        ST_READ_PTE = 2'd2,
        ST_DONE     = 2'd3
    } walk_state_t;

    typedef enum logic {
        LVL_DIR   = 1'b0,
        LVL_TABLE = 1'b1
    } walk_level_t;

endpackage

// File: rtl/pgw_addr_split.sv
module pgw_addr_split #(
    parameter int DIR_W    = 10,
    parameter int TBL_W    = 10,
    parameter int OFS_W    = 12,
    parameter int ENT_LOG2 = 2,
    localparam int ADDR_W  = DIR_W + TBL_W + OFS_W,
    localparam int BIG_W   = TBL_W + OFS_W
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic [ADDR_W-1:0] tbl_base,
    output logic [ADDR_W-1:0] dir_ptr,
    output logic [ADDR_W-1:0] tbl_ptr,
    output logic [ADDR_W-1:0] low_small,
    output logic [ADDR_W-1:0] low_large
);

    logic [DIR_W-1:0] dir_idx;
    logic [TBL_W-1:0] tbl_idx;

    assign dir_idx = vaddr[ADDR_W-1 -: DIR_W];
    assign tbl_idx = vaddr[BIG_W-1 -: TBL_W];

    // entry address = table base + index scaled by entry size
    assign dir_ptr = dir_base
                   + {{(ADDR_W-DIR_W-ENT_LOG2){1'b0}}, dir_idx, {ENT_LOG2{1'b0}}};
    assign tbl_ptr = tbl_base
                   + {{(ADDR_W-TBL_W-ENT_LOG2){1'b0}}, tbl_idx, {ENT_LOG2{1'b0}}};

    assign low_small = {{(ADDR_W-OFS_W){1'b0}}, vaddr[OFS_W-1:0]};
    assign low_large = {{(ADDR_W-BIG_W){1'b0}}, vaddr[BIG_W-1:0]};

endmodule

// File: rtl/pgw_entry_decode.sv
module pgw_entry_decode #(
    parameter int ADDR_W      = 32,
    parameter int OFS_W       = 12,
    parameter int TBL_W       = 10,
    parameter int PRESENT_BIT = 0,
    parameter int LARGE_BIT   = 7,
    localparam int BIG_W      = TBL_W + OFS_W
) (
    input  logic [ADDR_W-1:0] entry,
    output logic              present,
    output logic              big,
    output logic [ADDR_W-1:0] frame_base,
    output logic [ADDR_W-1:0] big_base
);

    assign present    = entry[PRESENT_BIT];
    assign big        = entry[LARGE_BIT];
    assign frame_base = {entry[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    assign big_base   = {entry[ADDR_W-1:BIG_W], {BIG_W{1'b0}}};

endmodule

// File: rtl/pgw_fsm.sv
module pgw_fsm
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] dir_base,
    output logic              req_ready,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic              ent_present,
    input  logic              ent_big,
    input  logic [ADDR_W-1:0] ent_frame_base,
    input  logic [ADDR_W-1:0] ent_big_base,
    input  logic [ADDR_W-1:0] dir_ptr,
    input  logic [ADDR_W-1:0] tbl_ptr,
    input  logic [ADDR_W-1:0] low_small,
    input  logic [ADDR_W-1:0] low_large,
    output logic [ADDR_W-1:0] va_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] tbl_base_q,
    output logic              resp_valid,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic              resp_fault,
    output logic              resp_level,
    output logic              resp_large
);

    walk_state_t state_q, state_d;
    logic        pending_q;
    logic        data_in;
    logic [ADDR_W-1:0] paddr_q;
    logic        fault_q, large_q;
    walk_level_t level_q;

    assign data_in = pending_q && mem_rd_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_READ_DIR;
            ST_READ_DIR: if (data_in) begin
                             if (!ent_present || ent_big) state_d = ST_DONE;
                             else                         state_d = ST_READ_PTE;
                         end
            ST_READ_PTE: if (data_in) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        mem_rd_req  = 1'b0;
        mem_rd_addr = dir_ptr;
        resp_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_READ_DIR: mem_rd_req = !pending_q;
            ST_READ_PTE: begin
                             mem_rd_req  = !pending_q;
                             mem_rd_addr = tbl_ptr;
                         end
            ST_DONE:     resp_valid = 1'b1;
            default:     req_ready = 1'b0;
        endcase
    end

    assign resp_paddr = paddr_q;
    assign resp_fault = fault_q;
    assign resp_level = level_q;
    assign resp_large = large_q;

    // outstanding-read tracker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pending_q <= 1'b0;
        else if (mem_rd_req) pending_q <= 1'b1;
        else if (data_in)    pending_q <= 1'b0;
    end

    // request capture and walk results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q       <= '0;
            base_q     <= '0;
            tbl_base_q <= '0;
            paddr_q    <= '0;
            fault_q    <= 1'b0;
            level_q    <= LVL_DIR;
            large_q    <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                va_q   <= req_vaddr;
                base_q <= dir_base;
            end
            if (state_q == ST_READ_DIR && data_in) begin
                level_q <= LVL_DIR;
                if (!ent_present) begin
                    fault_q <= 1'b1;
                    large_q <= 1'b0;
                    paddr_q <= '0;
                end else if (ent_big) begin
                    fault_q <= 1'b0;
                    large_q <= 1'b1;
                    paddr_q <= ent_big_base | low_large;
                end else begin
                    tbl_base_q <= ent_frame_base;
                end
            end
            if (state_q == ST_READ_PTE && data_in) begin
                level_q <= LVL_TABLE;
                large_q <= 1'b0;
                fault_q <= !ent_present;
                paddr_q <= ent_present ? (ent_frame_base | low_small) : '0;
            end
        end
    end

    a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_req && !resp_valid));

    a_r2_dir_read_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_req && !req_ready));

    a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !mem_rd_valid) |=> !mem_rd_req);

    a_r5_large_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_large) |-> (!resp_fault && resp_level == LVL_DIR));

    a_r4_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == '0 && !resp_large));

    a_r9_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> req_ready);

    a_r11_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !resp_valid) |=> ($stable(va_q) && $stable(base_q)));

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
    parameter int DIR_W       = 10,
    parameter int TBL_W       = 10,
    parameter int OFS_W       = 12,
    parameter int ENT_LOG2    = 2,
    parameter int PRESENT_BIT = 0,
    parameter int LARGE_BIT   = 7,
    localparam int ADDR_W     = DIR_W + TBL_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] dir_base,
    output logic              req_ready,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              resp_valid,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic              resp_fault,
    output logic              resp_level,
    output logic              resp_large
);

    logic [ADDR_W-1:0] va_q, base_q, tbl_base_q;
    logic [ADDR_W-1:0] dir_ptr, tbl_ptr, low_small, low_large;
    logic              ent_present, ent_big;
    logic [ADDR_W-1:0] ent_frame_base, ent_big_base;

    pgw_addr_split #(
        .DIR_W(DIR_W), .TBL_W(TBL_W), .OFS_W(OFS_W), .ENT_LOG2(ENT_LOG2)
    ) u_split (
        .vaddr     (va_q),
        .dir_base  (base_q),
        .tbl_base  (tbl_base_q),
        .dir_ptr   (dir_ptr),
        .tbl_ptr   (tbl_ptr),
        .low_small (low_small),
        .low_large (low_large)
    );

    pgw_entry_decode #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .TBL_W(TBL_W),
        .PRESENT_BIT(PRESENT_BIT), .LARGE_BIT(LARGE_BIT)
    ) u_decode (
        .entry      (mem_rd_data),
        .present    (ent_present),
        .big        (ent_big),
        .frame_base (ent_frame_base),
        .big_base   (ent_big_base)
    );

    pgw_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_vaddr      (req_vaddr),
        .dir_base       (dir_base),
        .req_ready      (req_ready),
        .mem_rd_req     (mem_rd_req),
        .mem_rd_addr    (mem_rd_addr),
        .mem_rd_valid   (mem_rd_valid),
        .ent_present    (ent_present),
        .ent_big        (ent_big),
        .ent_frame_base (ent_frame_base),
        .ent_big_base   (ent_big_base),
        .dir_ptr        (dir_ptr),
        .tbl_ptr        (tbl_ptr),
        .low_small      (low_small),
        .low_large      (low_large),
        .va_q           (va_q),
        .base_q         (base_q),
        .tbl_base_q     (tbl_base_q),
        .resp_valid     (resp_valid),
        .resp_paddr     (resp_paddr),
        .resp_fault     (resp_fault),
        .resp_level     (resp_level),
        .resp_large     (resp_large)
    );

endmodule

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] dir_base = '0;
    logic        req_ready;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_fault;
    logic        resp_level;
    logic        resp_large;

    always #4 clk = ~clk;  // 125 MHz

    pgwalk_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .dir_base(dir_base), .req_ready(req_ready), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .resp_valid(resp_valid),
        .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .resp_level(resp_level), .resp_large(resp_large)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] mem_a [32];
    logic [31:0] mem_d [32];
    int          mem_n = 0;
    logic [31:0] rd_log [8];
    int          rd_cnt = 0;
    int          overlap = 0;
    int          lat = 1;
    int          cnt = 0;
    logic [31:0] pend_addr = '0;
    int          stray_req = 0;
    int          stray_done = 0;

    task automatic mem_set(input logic [31:0] a, input logic [31:0] d);
        mem_a[mem_n] = a;
        mem_d[mem_n] = d;
        mem_n++;
    endtask

    function automatic logic [31:0] mem_get(input logic [31:0] a);
        logic [31:0] r = '0;
        for (int i = 0; i < mem_n; i++) if (mem_a[i] == a) r = mem_d[i];
        return r;
    endfunction

    always @(negedge clk) begin
        mem_rd_valid = 1'b0;
        if (stray_req != stray_done) begin
            stray_done = stray_req;
            mem_rd_valid = 1'b1;
            mem_rd_data = 32'hFFFF_FFFF;
        end
        if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
                mem_rd_valid = 1'b1;
                mem_rd_data = mem_get(pend_addr);
            end
        end
        if (rst_n && mem_rd_req) begin
            if (cnt != 0) overlap++;
            if (rd_cnt < 8) rd_log[rd_cnt] = mem_rd_addr;
            rd_cnt++;
            pend_addr = mem_rd_addr;
            cnt = lat;
        end
    end

    // expected values from the requirements
    function automatic logic [31:0] dir_addr(input logic [31:0] b, input logic [31:0] va);
        return b + {20'b0, va[31:22], 2'b00};
    endfunction
    function automatic logic [31:0] tbl_addr(input logic [31:0] pde, input logic [31:0] va);
        return {pde[31:12], 12'b0} + {20'b0, va[21:12], 2'b00};
    endfunction

    task automatic run_walk(input string tag, input logic [31:0] va, input logic [31:0] b,
                            input int lat_i, input bit busy_inj, input int exp_reads,
                            input logic [31:0] exp_a0, input logic [31:0] exp_a1,
                            input logic [31:0] exp_pa, input bit exp_fault,
                            input bit exp_lvl, input bit exp_large);
        int n = 0;
        @(negedge clk);
        rd_cnt = 0;
        overlap = 0;
        lat = lat_i;
        chk(req_ready == 1'b1, "R1", {tag, " ready before request"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        dir_base = b;
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = ~va;         // R11: inputs change after acceptance
        dir_base = ~b;
        chk(mem_rd_req == 1'b1, "R2", {tag, " read issued after accept"}, 32'(mem_rd_req), 32'd1);
        while (!resp_valid && n < 100) begin
            @(negedge clk);
            n++;
            if (busy_inj && n == 1) begin
                req_valid = 1'b1;   // R10: request while busy
                req_vaddr = 32'h0000_0000;
            end
            if (busy_inj && n == 2) req_valid = 1'b0;
        end
        req_valid = 1'b0;
        chk(resp_valid == 1'b1, "R9", {tag, " response arrives"}, 32'(resp_valid), 32'd1);
        chk(rd_cnt == exp_reads, "R6", {tag, " read count"}, 32'(rd_cnt), 32'(exp_reads));
        chk(overlap == 0, "R3", {tag, " no read while one outstanding"}, 32'(overlap), 32'd0);
        if (rd_cnt >= 1)
            chk(rd_log[0] == exp_a0, "R2", {tag, " directory entry address"}, rd_log[0], exp_a0);
        if (exp_reads == 2 && rd_cnt >= 2)
            chk(rd_log[1] == exp_a1, "R6", {tag, " table entry address"}, rd_log[1], exp_a1);
        chk(resp_paddr == exp_pa, "R8", {tag, " physical address (R5/R11)"}, resp_paddr, exp_pa);
        chk(resp_fault == exp_fault, "R4", {tag, " fault flag (R7)"}, 32'(resp_fault), 32'(exp_fault));
        if (exp_fault)
            chk(resp_level == exp_lvl, "R7", {tag, " fault level"}, 32'(resp_level), 32'(exp_lvl));
        chk(resp_large == exp_large, "R5", {tag, " large flag"}, 32'(resp_large), 32'(exp_large));
        @(negedge clk);
        chk(resp_valid == 1'b0, "R9", {tag, " response one cycle"}, 32'(resp_valid), 32'd0);
        chk(req_ready == 1'b1, "R9", {tag, " ready again"}, 32'(req_ready), 32'd1);
        chk(rd_cnt == exp_reads, "R10", {tag, " no extra walk"}, 32'(rd_cnt), 32'(exp_reads));
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'd1);
        chk(mem_rd_req == 1'b0, "R1", "reset no read", 32'(mem_rd_req), 32'd0);
        chk(resp_valid == 1'b0, "R1", "reset no response", 32'(resp_valid), 32'd0);
    endtask

    task automatic test_stray();
        @(negedge clk);
        rd_cnt = 0;
        stray_req++;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R10", "stray data leaves walker idle", 32'(req_ready), 32'd1);
        chk(resp_valid == 1'b0, "R10", "stray data gives no response", 32'(resp_valid), 32'd0);
        chk(rd_cnt == 0, "R10", "stray data starts no read", 32'(rd_cnt), 32'd0);
    endtask

    localparam logic [31:0] B0 = 32'h0004_0000;
    localparam logic [31:0] B1 = 32'h0020_0000;

    initial begin
        // R6/R8 small page, index 0x48
        mem_set(dir_addr(B0, 32'h1234_5678), 32'h0008_1003);
        mem_set(tbl_addr(32'h0008_1003, 32'h1234_5678), 32'hABCD_E001);
        // top directory index, table entry with bit 7 set (ignored, R8)
        mem_set(dir_addr(B0, 32'hFFC0_1ABC), 32'h0009_0001);
        mem_set(tbl_addr(32'h0009_0001, 32'hFFC0_1ABC), 32'h0123_4081);
        // large page at directory index 1
        mem_set(dir_addr(B0, 32'h007F_FFFF), 32'hC000_0081);
        // not-present directory entry with large bit set
        mem_set(dir_addr(B0, 32'h8000_0000), 32'h0000_0080);
        // index zero on second base
        mem_set(dir_addr(B1, 32'h0000_0FFF), 32'h0030_0001);
        mem_set(tbl_addr(32'h0030_0001, 32'h0000_0FFF), 32'h0000_5001);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_walk("small page lat1", 32'h1234_5678, B0, 1, 0, 2,
                 dir_addr(B0, 32'h1234_5678), tbl_addr(32'h0008_1003, 32'h1234_5678),
                 {32'hABCD_E001 >> 12, 12'h678} , 0, 0, 0);
        run_walk("top index busy lat3", 32'hFFC0_1ABC, B0, 3, 1, 2,
                 dir_addr(B0, 32'hFFC0_1ABC), tbl_addr(32'h0009_0001, 32'hFFC0_1ABC),
                 32'h0123_4ABC, 0, 0, 0);
        run_walk("large page", 32'h007F_FFFF, B0, 2, 0, 1,
                 dir_addr(B0, 32'h007F_FFFF), 32'h0,
                 {10'(32'hC000_0081 >> 22), 22'h3F_FFFF}, 0, 0, 1);
        run_walk("directory fault R4", 32'h8000_0000, B0, 1, 0, 1,
                 dir_addr(B0, 32'h8000_0000), 32'h0, 32'h0, 1, 0, 0);
        run_walk("table fault R7", 32'h1234_7000, B0, 2, 0, 2,
                 dir_addr(B0, 32'h1234_7000), tbl_addr(32'h0008_1003, 32'h1234_7000),
                 32'h0, 1, 1, 0);
        test_stray();
        run_walk("index zero after stray", 32'h0000_0FFF, B1, 2, 0, 2,
                 dir_addr(B1, 32'h0000_0FFF), tbl_addr(32'h0030_0001, 32'h0000_0FFF),
                 32'h0000_5FFF, 0, 0, 0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule